// File: doc/BRIEF.md
# Ingress Frame Capture with Descriptors

This block is the receive half of a store-and-delay frame buffer. It takes frames from a 32-bit streaming source that uses valid/ready flow control, with start-of-packet, end-of-packet and empty qualifiers. Every accepted beat of a frame is written through, in the same cycle, to an external packet data FIFO. Alongside the data, the block counts the frame's bytes. When the first beat arrives it stamps the frame with a release time: the value of a free-running 32-bit cycle counter plus a programmable delay. A later egress stage compares that release time against the same counter to decide when the frame may leave.

When the last beat of a frame has been accepted, the block forms a 48-bit descriptor and pushes it into a descriptor FIFO. The release time sits in the upper 32 bits and the byte count in the lower 16 bits. The block measures free space from the data FIFO's word occupancy. Once less than one maximum-size frame of space remains, it stops offering ready between frames. A frame already in flight is always completed.

A synchronous soft reset abandons any partial frame without pushing a descriptor. It leaves the cycle counter running.

Top module: `frame_ingress_capture`

## Requirements
- R1: After `rst`, `snk_ready` is high when `fifo_level` is 0, and neither `dat_wr_en` nor `desc_wr_en` is asserted.
- R2: A beat accepted (`snk_valid` and `snk_ready`) that opens a frame (`snk_sop`=1) or continues an open frame raises `dat_wr_en` in the same cycle, with `dat_wr_data` equal to `snk_data`.
- R3: A valid beat that arrives while no frame is open and carries `snk_sop`=0 is discarded: it causes no `dat_wr_en` and no descriptor.
- R4: The frame byte count adds 4 for every accepted non-final beat. On the end-of-packet beat it adds 4 minus `snk_empty` (empty 0..3 gives 4..1 bytes). A single-beat frame therefore counts 4 minus `snk_empty`.
- R5: `desc_wr_en` pulses for exactly one cycle, in the cycle after the accepted end-of-packet beat. `desc_wr_data[47:16]` holds the release time and `desc_wr_data[15:0]` holds the byte count.
- R6: The release time equals the cycle counter's value at the start-of-packet beat plus `delay_cfg`, taken modulo 2^32. The counter is 0 in the first cycle after `rst` and then increments by one every cycle.
- R7: While `snk_valid` is low in the middle of a frame, nothing is written and the byte count and release time are unchanged.
- R8: Free space is 1024 minus `fifo_level`, in 32-bit words. Between frames, `snk_ready` is low whenever free space is below 380 words (one 1518-byte frame) and high otherwise. Once a frame is open, `snk_ready` stays high until its end-of-packet beat, whatever the level does.
- R9: A one-cycle `soft_rst` closes any open frame and clears its count without pushing a descriptor. Beats without start-of-packet that follow are discarded. The cycle counter is not affected.
- R10: A start-of-packet beat that arrives while a frame is already open restarts the frame. It takes a new release time, and its byte count starts from that beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| soft_rst | input | 1 | Synchronous abandon of the frame in progress |
| delay_cfg | input | 32 | Delay added to the counter to form the release time |
| snk_data | input | 32 | Sink data beat |
| snk_valid | input | 1 | Sink beat valid |
| snk_sop | input | 1 | First beat of a frame |
| snk_eop | input | 1 | Last beat of a frame |
| snk_empty | input | 2 | Unused bytes in the last beat |
| snk_ready | output | 1 | Block accepts a beat this cycle |
| fifo_level | input | 11 | Data FIFO occupancy in words |
| dat_wr_en | output | 1 | Data FIFO write strobe |
| dat_wr_data | output | 32 | Data FIFO write word |
| desc_wr_en | output | 1 | Descriptor FIFO write strobe |
| desc_wr_data | output | 48 | Descriptor: release time and byte count |

## Verification
The bench targets the final-beat byte arithmetic for every empty value, including single-beat frames. A design that ignored empty, or added it instead of subtracting it, would report wrong lengths. A pause inside a frame is checked because a design that counted beats on edges rather than on handshakes would inflate the count. The release time is checked with a delay that makes the sum wrap past 2^32, which exposes a truncated or saturating adder. Backpressure is probed at 644 and 645 words of occupancy and with the level rising during a frame. An off-by-one threshold, or a ready that drops mid-frame, shows up there. Soft reset, stray beats without a start and a repeated start are exercised; a design that leaked a stale descriptor, or kept accumulating into the old count, fails those checks.

// File: rtl/ingress_pkg.sv
package ingress_pkg;

    localparam int WORD_W     = 32;
    localparam int EMPTY_W    = 2;
    localparam int TS_W       = 32;
    localparam int CNT_W      = 16;
    localparam int BEAT_BYTES = WORD_W / 8;
    localparam int DESC_W     = TS_W + CNT_W;

    typedef struct packed {
        logic [TS_W-1:0]  release_time;
        logic [CNT_W-1:0] byte_count;
    } frame_desc_t;

    // bytes carried by one accepted beat
    function automatic logic [CNT_W-1:0] beat_bytes(input logic last,
                                                    input logic [EMPTY_W-1:0] empty);
        logic [CNT_W-1:0] full_b;
        full_b = CNT_W'(BEAT_BYTES);
        if (last)
            return full_b - CNT_W'(empty);
        return full_b;
    endfunction

endpackage

// File: rtl/ingress_cycle_counter.sv
module ingress_cycle_counter
    import ingress_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    output logic [TS_W-1:0] now
);

    always_ff @(posedge clk) begin
        if (rst)
            now <= '0;
        else
            now <= now + 1'b1;
    end

endmodule

// File: rtl/ingress_space_monitor.sv
module ingress_space_monitor #(
    parameter int FIFO_WORDS = 1024,
    parameter int HEAD_WORDS = 380,
    parameter int LVL_W      = 11
) (
    input  logic [LVL_W-1:0] level,
    output logic             room_ok
);

    localparam logic [LVL_W:0] DEPTH_L = (LVL_W+1)'(FIFO_WORDS);
    localparam logic [LVL_W:0] HEAD_L  = (LVL_W+1)'(HEAD_WORDS);

    logic [LVL_W:0] free_w;

    always_comb begin
        free_w  = DEPTH_L - {1'b0, level};
        room_ok = ({1'b0, level} <= DEPTH_L) && (free_w >= HEAD_L);
    end

endmodule

// File: rtl/ingress_frame_tracker.sv
module ingress_frame_tracker
    import ingress_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic               take,
    input  logic               sop,
    input  logic               eop,
    input  logic [EMPTY_W-1:0] empty,
    input  logic [TS_W-1:0]    now,
    input  logic [TS_W-1:0]    delay,
    output logic               in_frame,
    output logic               keep,
    output logic               desc_valid,
    output frame_desc_t        desc
);

    logic [CNT_W-1:0] run_count;
    logic [TS_W-1:0]  run_release;
    logic [CNT_W-1:0] add_b;
    logic [CNT_W-1:0] next_count;
    logic [TS_W-1:0]  next_release;

    always_comb begin
        keep         = take && (sop || in_frame) && !soft_rst;
        add_b        = beat_bytes(eop, empty);
        next_count   = sop ? add_b : (run_count + add_b);
        next_release = sop ? (now + delay) : run_release;
    end

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            in_frame    <= 1'b0;
            run_count   <= '0;
            run_release <= '0;
            desc_valid  <= 1'b0;
            desc        <= '0;
        end else begin
            desc_valid <= 1'b0;
            if (keep) begin
                run_count   <= next_count;
                run_release <= next_release;
                if (eop) begin
                    in_frame          <= 1'b0;
                    desc_valid        <= 1'b1;
                    desc.release_time <= next_release;
                    desc.byte_count   <= next_count;
                end else begin
                    in_frame <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/frame_ingress_capture.sv
module frame_ingress_capture
    import ingress_pkg::*;
#(
    parameter int FIFO_WORDS      = 1024,
    parameter int MAX_FRAME_BYTES = 1518,
    localparam int HEAD_WORDS     = (MAX_FRAME_BYTES + BEAT_BYTES - 1) / BEAT_BYTES,
    localparam int LVL_W          = $clog2(FIFO_WORDS + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               soft_rst,
    input  logic [TS_W-1:0]    delay_cfg,
    input  logic [WORD_W-1:0]  snk_data,
    input  logic               snk_valid,
    input  logic               snk_sop,
    input  logic               snk_eop,
    input  logic [EMPTY_W-1:0] snk_empty,
    output logic               snk_ready,
    input  logic [LVL_W-1:0]   fifo_level,
    output logic               dat_wr_en,
    output logic [WORD_W-1:0]  dat_wr_data,
    output logic               desc_wr_en,
    output logic [DESC_W-1:0]  desc_wr_data
);

    logic            room_ok;
    logic            in_frame;
    logic            keep;
    logic            take;
    logic [TS_W-1:0] now;
    frame_desc_t     desc;

    ingress_cycle_counter u_clock (
        .clk (clk),
        .rst (rst),
        .now (now)
    );

    ingress_space_monitor #(
        .FIFO_WORDS (FIFO_WORDS),
        .HEAD_WORDS (HEAD_WORDS),
        .LVL_W      (LVL_W)
    ) u_space (
        .level   (fifo_level),
        .room_ok (room_ok)
    );

    // a frame in flight keeps ready high so it always completes
    assign snk_ready = in_frame || room_ok;
    assign take      = snk_valid && snk_ready;

    ingress_frame_tracker u_track (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (soft_rst),
        .take       (take),
        .sop        (snk_sop),
        .eop        (snk_eop),
        .empty      (snk_empty),
        .now        (now),
        .delay      (delay_cfg),
        .in_frame   (in_frame),
        .keep       (keep),
        .desc_valid (desc_wr_en),
        .desc       (desc)
    );

    assign dat_wr_en    = keep;
    assign dat_wr_data  = snk_data;
    assign desc_wr_data = desc;

endmodule

// File: rtl/ingress_capture_checker.sv
module ingress_capture_checker #(
    parameter int FIFO_WORDS = 1024,
    parameter int HEAD_WORDS = 380,
    parameter int LVL_W      = 11
) (
    input logic             clk,
    input logic             rst,
    input logic             soft_rst,
    input logic             snk_valid,
    input logic             snk_sop,
    input logic             snk_eop,
    input logic             snk_ready,
    input logic [LVL_W-1:0] fifo_level,
    input logic             dat_wr_en,
    input logic             desc_wr_en,
    input logic [47:0]      desc_wr_data,
    input logic             in_frame
);

    AST_WR_ON_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
        dat_wr_en |-> (snk_valid && snk_ready)); // R2

    AST_STRAY_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && !snk_sop) |-> !dat_wr_en); // R3

    AST_COUNT_NONZERO: assert property (@(posedge clk) disable iff (rst)
        desc_wr_en |-> (desc_wr_data[15:0] != 16'd0)); // R4

    AST_DESC_AFTER_EOP: assert property (@(posedge clk) disable iff (rst)
        desc_wr_en |-> $past(dat_wr_en && snk_eop)); // R5

    AST_PAUSE_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        !snk_valid |-> !dat_wr_en); // R7

    AST_READY_HELD_IN_FRAME: assert property (@(posedge clk) disable iff (rst)
        (dat_wr_en && !snk_eop && !soft_rst) |=> snk_ready); // R8

    AST_NO_ROOM_NO_READY: assert property (@(posedge clk) disable iff (rst)
        (!in_frame && ((FIFO_WORDS - int'(fifo_level)) < HEAD_WORDS)) |-> !snk_ready); // R8

    AST_SOFT_CLOSES: assert property (@(posedge clk) disable iff (rst)
        soft_rst |=> (!in_frame && !desc_wr_en)); // R9

endmodule

bind frame_ingress_capture ingress_capture_checker #(
    .FIFO_WORDS (FIFO_WORDS),
    .HEAD_WORDS (HEAD_WORDS),
    .LVL_W      (LVL_W)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .soft_rst     (soft_rst),
    .snk_valid    (snk_valid),
    .snk_sop      (snk_sop),
    .snk_eop      (snk_eop),
    .snk_ready    (snk_ready),
    .fifo_level   (fifo_level),
    .dat_wr_en    (dat_wr_en),
    .desc_wr_en   (desc_wr_en),
    .desc_wr_data (desc_wr_data),
    .in_frame     (in_frame)
);

// File: tb/test_frame_ingress_capture.sv
module test_frame_ingress_capture;

    logic        clk = 1'b0;
    logic        rst;
    logic        soft_rst;
    logic [31:0] delay_cfg;
    logic [31:0] snk_data;
    logic        snk_valid;
    logic        snk_sop;
    logic        snk_eop;
    logic [1:0]  snk_empty;
    logic        snk_ready;
    logic [10:0] fifo_level;
    logic        dat_wr_en;
    logic [31:0] dat_wr_data;
    logic        desc_wr_en;
    logic [47:0] desc_wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] mdl_time;
    logic [31:0] exp_ts;

    always #5 clk = ~clk;

    frame_ingress_capture i_frame_ingress_capture (
        .clk          (clk),
        .rst          (rst),
        .soft_rst     (soft_rst),
        .delay_cfg    (delay_cfg),
        .snk_data     (snk_data),
        .snk_valid    (snk_valid),
        .snk_sop      (snk_sop),
        .snk_eop      (snk_eop),
        .snk_empty    (snk_empty),
        .snk_ready    (snk_ready),
        .fifo_level   (fifo_level),
        .dat_wr_en    (dat_wr_en),
        .dat_wr_data  (dat_wr_data),
        .desc_wr_en   (desc_wr_en),
        .desc_wr_data (desc_wr_data)
    );

    // reference cycle counter built from R6
    always_ff @(posedge clk) begin
        if (rst) mdl_time <= '0;
        else     mdl_time <= mdl_time + 1'b1;
    end

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // called at a negedge; returns at the next negedge
    task automatic beat(input logic [31:0] d, input logic s, input logic e,
                        input logic [1:0] emp, input logic exp_wr, input string req);
        snk_data = d; snk_valid = 1'b1; snk_sop = s; snk_eop = e; snk_empty = emp;
        #1;
        chk(req, dat_wr_en, exp_wr);
        if (exp_wr) chk(req, dat_wr_data, d);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        snk_valid = 1'b0; snk_sop = 1'b0; snk_eop = 1'b0; snk_empty = 2'd0;
        for (int i = 0; i < n; i++) begin
            #1;
            chk("R7 no write while idle", dat_wr_en, 1'b0);
            @(negedge clk);
        end
    endtask

    task automatic chk_desc(input logic [31:0] ts, input logic [15:0] cnt, input string req);
        chk(req, desc_wr_en, 1'b1);
        chk(req, desc_wr_data[47:16], ts);
        chk(req, desc_wr_data[15:0], cnt);
    endtask

    task automatic t_reset;
        rst = 1'b1; soft_rst = 1'b0; delay_cfg = 32'd0; fifo_level = '0;
        snk_data = '0; snk_valid = 1'b0; snk_sop = 1'b0; snk_eop = 1'b0; snk_empty = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 ready after reset", snk_ready, 1'b1);
        chk("R1 no data write", dat_wr_en, 1'b0);
        chk("R1 no descriptor", desc_wr_en, 1'b0);
    endtask

    task automatic t_multi_beat;
        delay_cfg = 32'd100;
        exp_ts = mdl_time + delay_cfg;
        beat(32'hA0A0_0001, 1, 0, 2'd0, 1, "R2 first beat");
        beat(32'hA0A0_0002, 0, 0, 2'd0, 1, "R2 middle beat");
        beat(32'hA0A0_0003, 0, 1, 2'd2, 1, "R2 last beat");
        chk_desc(exp_ts, 16'd10, "R4 R5 R6 three-beat frame");
        idle(1);
        chk("R5 descriptor single pulse", desc_wr_en, 1'b0);
    endtask

    task automatic t_single_beat;
        for (int e = 0; e < 4; e++) begin
            exp_ts = mdl_time + delay_cfg;
            beat(32'h5100 + e, 1, 1, 2'(e), 1, "R4 single beat write");
            chk_desc(exp_ts, 16'(4 - e), "R4 single beat count");
            idle(1);
        end
    endtask

    task automatic t_pause;
        delay_cfg = 32'd7;
        exp_ts = mdl_time + delay_cfg;
        beat(32'hC0DE_0001, 1, 0, 2'd0, 1, "R7 before pause");
        idle(3);
        chk("R7 no descriptor in pause", desc_wr_en, 1'b0);
        beat(32'hC0DE_0002, 0, 0, 2'd0, 1, "R7 after pause");
        idle(2);
        beat(32'hC0DE_0003, 0, 1, 2'd0, 1, "R7 last beat");
        chk_desc(exp_ts, 16'd12, "R7 count across pauses");
        idle(1);
    endtask

    task automatic t_stray;
        beat(32'hDEAD_0001, 0, 0, 2'd0, 0, "R3 stray beat");
        beat(32'hDEAD_0002, 0, 1, 2'd1, 0, "R3 stray end");
        chk("R3 no descriptor from stray", desc_wr_en, 1'b0);
        idle(1);
    endtask

    task automatic t_wrap;
        idle(300);
        delay_cfg = 32'hFFFF_FF00;
        exp_ts = mdl_time + delay_cfg;
        beat(32'h0000_0A0A, 1, 0, 2'd0, 1, "R6 wrap first");
        beat(32'h0000_0B0B, 0, 1, 2'd3, 1, "R6 wrap last");
        chk_desc(exp_ts, 16'd5, "R6 release time wraps");
        idle(1);
    endtask

    task automatic t_backpressure;
        fifo_level = 11'd645;
        #1;
        chk("R8 ready low at 379 free", snk_ready, 1'b0);
        beat(32'hBB00_0001, 1, 0, 2'd0, 0, "R8 start refused");
        idle(1);
        fifo_level = 11'd644;
        #1;
        chk("R8 ready high at 380 free", snk_ready, 1'b1);
        delay_cfg = 32'd3;
        exp_ts = mdl_time + delay_cfg;
        beat(32'hBB00_0002, 1, 0, 2'd0, 1, "R8 start taken");
        fifo_level = 11'd1000;
        #1;
        chk("R8 ready held in frame", snk_ready, 1'b1);
        beat(32'hBB00_0003, 0, 0, 2'd0, 1, "R8 middle taken");
        beat(32'hBB00_0004, 0, 1, 2'd1, 1, "R8 end taken");
        chk_desc(exp_ts, 16'd11, "R8 frame completes");
        chk("R8 ready drops after frame", snk_ready, 1'b0);
        idle(1);
        fifo_level = 11'd0;
        #1;
        chk("R8 ready returns", snk_ready, 1'b1);
        @(negedge clk);
    endtask

    task automatic t_soft;
        logic [31:0] t_before;
        beat(32'h50F7_0001, 1, 0, 2'd0, 1, "R9 open frame");
        beat(32'h50F7_0002, 0, 0, 2'd0, 1, "R9 second beat");
        idle(1);
        t_before = mdl_time;
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk("R9 no descriptor on abandon", desc_wr_en, 1'b0);
        chk("R9 counter keeps running", mdl_time, t_before + 32'd1);
        beat(32'h50F7_0003, 0, 0, 2'd0, 0, "R9 continuation dropped");
        beat(32'h50F7_0004, 0, 1, 2'd0, 0, "R9 end dropped");
        chk("R9 no descriptor after abandon", desc_wr_en, 1'b0);
        exp_ts = mdl_time + delay_cfg;
        beat(32'h50F7_0005, 1, 1, 2'd1, 1, "R9 fresh frame");
        chk_desc(exp_ts, 16'd3, "R9 fresh count");
        idle(1);
    endtask

    task automatic t_restart;
        delay_cfg = 32'd40;
        beat(32'h4E57_0001, 1, 0, 2'd0, 1, "R10 first start");
        beat(32'h4E57_0002, 0, 0, 2'd0, 1, "R10 first body");
        delay_cfg = 32'd90;
        exp_ts = mdl_time + delay_cfg;
        beat(32'h4E57_0003, 1, 0, 2'd0, 1, "R10 second start");
        beat(32'h4E57_0004, 0, 1, 2'd2, 1, "R10 second end");
        chk_desc(exp_ts, 16'd6, "R10 restarted frame");
        idle(1);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_multi_beat();
        t_single_beat();
        t_pause();
        t_stray();
        t_wrap();
        t_backpressure();
        t_soft();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #2000000;
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule